// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a parallel flash-style host bus and the engine that performs program and erase operations. It watches the chip-select and write strobes, takes the address when a write cycle opens and the data when it closes, and walks a fixed multi-cycle unlock protocol. When a complete, legal sequence has been written, it raises a one-clock start pulse and presents the target address and data to the engine.

Five operations are decoded. Byte program takes three key cycles and one argument cycle. Sector erase and block erase each take six cycles. Erase suspend and erase resume each take a single cycle. While the engine reports busy, every write other than suspend is discarded. A low write-protect pin blocks erasure of the lowest block.

All bus inputs are assumed synchronous to `clk`. A write cycle is any interval in which both `bus_ce_n` and `bus_we_n` are low.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset all five start outputs are low and `op_addr` and `op_data` are zero.
- R2: The address of a write cycle is the value of `bus_addr` at the first clock where both strobes are low, which is the fall of whichever strobe falls later. Address changes later in the cycle have no effect, whichever strobe falls first.
- R3: The data of a write cycle is the value of `bus_data` at the last clock where both strobes are still low, which is just before the first strobe rises.
- R4: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a write of D at address A, raise `start_prog` for one clock, two clocks after the strobes of the fourth write release. At that point `op_addr`=A and `op_data`=D. Key addresses compare only the low 16 address bits.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 50h at address A, raise `start_sector_erase` with the same timing as R4. `op_addr` is A with bits 11:0 cleared (4 KB sectors) and `op_data`=50h.
- R6: The same five-write prefix followed by 30h at address A raises `start_block_erase`. `op_addr` is A with bits 15:0 cleared (64 KB blocks) and `op_data`=30h.
- R7: A write that does not match the expected step returns the decoder to idle with no start pulse. `op_addr` and `op_data` keep their values, and a following correct sequence is decoded normally.
- R8: While `engine_busy` is high, every write other than B0h raises no start and returns the decoder to idle.
- R9: B0h at any address while busy raises `start_suspend`. 30h at any address, written from idle while not busy, raises `start_resume`. B0h while not busy raises nothing. Suspend and resume leave `op_addr` and `op_data` unchanged.
- R10: If `wp_n` is low when the final erase write completes and address bits 20:16 are zero, the erase raises no start. Erases outside that block, erases with `wp_n` high, and programs into that block are not blocked.
- R11: At most one start output is high in any clock, and each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_addr | input | 21 | Bus byte address |
| bus_data | input | 8 | Bus write data |
| engine_busy | input | 1 | Program or erase operation in progress |
| wp_n | input | 1 | Write protect for the lowest block, active low |
| start_prog | output | 1 | One-clock byte program start |
| start_sector_erase | output | 1 | One-clock sector erase start |
| start_block_erase | output | 1 | One-clock block erase start |
| start_suspend | output | 1 | One-clock erase suspend request |
| start_resume | output | 1 | One-clock erase resume request |
| op_addr | output | 21 | Target address of the last program or erase |
| op_data | output | 8 | Data byte of the last program or erase |

## Verification
Results appear a fixed two clocks after the closing strobe rises. The first register flags the end of the write cycle. The second turns the decode into a start pulse and updates `op_addr` and `op_data`.

The bench releases strobes on a falling clock edge and samples on falling edges. It confirms that nothing is high one edge after release, that the expected pulse and operands are present on the second edge, and that the pulse is gone on the third. `engine_busy` and `wp_n` are held steady across each whole sequence, because they are sampled in the same clock that the write completes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT_AA,
    ST_GOT_55,
    ST_PROG_ARG,
    ST_ERA_SETUP,
    ST_ERA_AA,
    ST_ERA_55
  } seq_state_t;

  typedef enum logic [2:0] {
    ISS_NONE   = 3'd0,
    ISS_PROG   = 3'd1,
    ISS_SECT   = 3'd2,
    ISS_BLOCK  = 3'd3,
    ISS_SUSP   = 3'd4,
    ISS_RESUME = 3'd5
  } issue_t;

  localparam int NUM_ISS = 6;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECT    = 8'h50;
  localparam logic [7:0] CMD_BLOCK   = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cyc_done,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data
);

  logic act;
  logic act_q;
  logic addr_en;
  logic data_en;
  logic done_d;

  // Write cycle: both strobes low. It opens on the later fall and closes on the earlier rise.
  assign act     = ~ce_n & ~we_n;
  assign addr_en = act & ~act_q;
  assign data_en = act;
  assign done_d  = ~act & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cyc_done <= 1'b0;
    end else begin
      act_q    <= act;
      cyc_done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_addr <= '0;
    end else if (addr_en) begin
      cyc_addr <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_data <= '0;
    end else if (data_en) begin
      cyc_data <= data_in;
    end
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int KEY_W       = 16,
  parameter int BLOCK_BITS  = 16,
  parameter int PROT_BLOCK  = 0,
  parameter logic [KEY_W-1:0] KEY_ADDR1 = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_ADDR2 = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_done,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic              busy,
  input  logic              wp_n,
  output issue_t            issue
);

  localparam int BIDX_W = ADDR_W - BLOCK_BITS;
  localparam logic [BIDX_W-1:0] PROT_IDX = BIDX_W'(PROT_BLOCK);

  seq_state_t state_q;
  seq_state_t state_d;

  logic at_key1;
  logic at_key2;
  logic prot_hit;
  logic d_key_a;
  logic d_key_b;
  logic d_prog;
  logic d_erase;
  logic d_sect;
  logic d_block;
  logic d_susp;
  logic d_resume;

  assign at_key1  = (cyc_addr[KEY_W-1:0] == KEY_ADDR1);
  assign at_key2  = (cyc_addr[KEY_W-1:0] == KEY_ADDR2);
  assign prot_hit = ~wp_n & (cyc_addr[ADDR_W-1:BLOCK_BITS] == PROT_IDX);

  assign d_key_a  = (cyc_data == DATA_W'(CMD_KEY_A));
  assign d_key_b  = (cyc_data == DATA_W'(CMD_KEY_B));
  assign d_prog   = (cyc_data == DATA_W'(CMD_PROG));
  assign d_erase  = (cyc_data == DATA_W'(CMD_ERASE));
  assign d_sect   = (cyc_data == DATA_W'(CMD_SECT));
  assign d_block  = (cyc_data == DATA_W'(CMD_BLOCK));
  assign d_susp   = (cyc_data == DATA_W'(CMD_SUSPEND));
  assign d_resume = (cyc_data == DATA_W'(CMD_RESUME));

  always_comb begin
    state_d = state_q;
    issue   = ISS_NONE;
    if (cyc_done) begin
      state_d = ST_IDLE;
      if (busy) begin
        if (d_susp) begin
          issue = ISS_SUSP;
        end
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (d_key_a && at_key1) begin
              state_d = ST_GOT_AA;
            end else if (d_resume) begin
              issue = ISS_RESUME;
            end
          end
          ST_GOT_AA: begin
            if (d_key_b && at_key2) state_d = ST_GOT_55;
          end
          ST_GOT_55: begin
            if (d_prog && at_key1) begin
              state_d = ST_PROG_ARG;
            end else if (d_erase && at_key1) begin
              state_d = ST_ERA_SETUP;
            end
          end
          ST_PROG_ARG: begin
            issue = ISS_PROG;
          end
          ST_ERA_SETUP: begin
            if (d_key_a && at_key1) state_d = ST_ERA_AA;
          end
          ST_ERA_AA: begin
            if (d_key_b && at_key2) state_d = ST_ERA_55;
          end
          ST_ERA_55: begin
            if (!prot_hit) begin
              if (d_sect) begin
                issue = ISS_SECT;
              end else if (d_block) begin
                issue = ISS_BLOCK;
              end
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (cyc_done) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int SECTOR_BITS = 12,
  parameter int BLOCK_BITS  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  issue_t              issue,
  input  logic [ADDR_W-1:0]   cyc_addr,
  input  logic [DATA_W-1:0]   cyc_data,
  output logic [NUM_ISS-1:1]  pulse,
  output logic [ADDR_W-1:0]   op_addr,
  output logic [DATA_W-1:0]   op_data
);

  localparam logic [ADDR_W-1:0] SECT_MASK  = ~ADDR_W'((64'd1 << SECTOR_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] BLOCK_MASK = ~ADDR_W'((64'd1 << BLOCK_BITS) - 64'd1);

  logic [NUM_ISS-1:1] pulse_d;
  logic               op_en;
  logic [ADDR_W-1:0]  op_addr_d;

  for (genvar k = 1; k < NUM_ISS; k++) begin : g_pulse
    assign pulse_d[k] = (32'(issue) == k);
  end

  assign op_en = (issue == ISS_PROG) || (issue == ISS_SECT) || (issue == ISS_BLOCK);

  always_comb begin
    unique case (issue)
      ISS_SECT:  op_addr_d = cyc_addr & SECT_MASK;
      ISS_BLOCK: op_addr_d = cyc_addr & BLOCK_MASK;
      default:   op_addr_d = cyc_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= '0;
    end else begin
      pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr <= '0;
      op_data <= '0;
    end else if (op_en) begin
      op_addr <= op_addr_d;
      op_data <= cyc_data;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int KEY_W       = 16,
  parameter int SECTOR_BITS = 12,
  parameter int BLOCK_BITS  = 16,
  parameter int PROT_BLOCK  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              engine_busy,
  input  logic              wp_n,
  output logic              start_prog,
  output logic              start_sector_erase,
  output logic              start_block_erase,
  output logic              start_suspend,
  output logic              start_resume,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  logic              rst_s1;
  logic              rst_sync_n;
  logic              cyc_done;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  issue_t            issue;
  logic [NUM_ISS-1:1] pulse;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  fcd_bus_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (bus_ce_n),
    .we_n     (bus_we_n),
    .addr_in  (bus_addr),
    .data_in  (bus_data),
    .cyc_done (cyc_done),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data)
  );

  fcd_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .KEY_W      (KEY_W),
    .BLOCK_BITS (BLOCK_BITS),
    .PROT_BLOCK (PROT_BLOCK)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cyc_done (cyc_done),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .busy     (engine_busy),
    .wp_n     (wp_n),
    .issue    (issue)
  );

  fcd_issue #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SECTOR_BITS (SECTOR_BITS),
    .BLOCK_BITS  (BLOCK_BITS)
  ) u_iss (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .issue    (issue),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .pulse    (pulse),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  assign start_prog         = pulse[ISS_PROG];
  assign start_sector_erase = pulse[ISS_SECT];
  assign start_block_erase  = pulse[ISS_BLOCK];
  assign start_suspend      = pulse[ISS_SUSP];
  assign start_resume       = pulse[ISS_RESUME];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W      = 21,
  parameter int SECTOR_BITS = 12,
  parameter int BLOCK_BITS  = 16,
  parameter int PROT_BLOCK  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              engine_busy,
  input logic              wp_n,
  input logic              start_prog,
  input logic              start_sector_erase,
  input logic              start_block_erase,
  input logic              start_suspend,
  input logic              start_resume,
  input logic [ADDR_W-1:0] op_addr
);

  localparam int BIDX_W = ADDR_W - BLOCK_BITS;
  localparam logic [BIDX_W-1:0] PROT_IDX = BIDX_W'(PROT_BLOCK);

  logic [4:0] starts;
  logic       non_susp;
  logic       erase_go;

  assign starts   = {start_prog, start_sector_erase, start_block_erase, start_suspend, start_resume};
  assign non_susp = start_prog | start_sector_erase | start_block_erase | start_resume;
  assign erase_go = start_sector_erase | start_block_erase;

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(starts)); // R11

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (|starts) |=> !(|starts)); // R11

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    non_susp |-> !$past(engine_busy)); // R8

  AST_SUSPEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_suspend |-> $past(engine_busy)); // R9

  AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    start_sector_erase |-> (op_addr[SECTOR_BITS-1:0] == '0)); // R5

  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    start_block_erase |-> (op_addr[BLOCK_BITS-1:0] == '0)); // R6

  AST_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> !(!$past(wp_n) && (op_addr[ADDR_W-1:BLOCK_BITS] == PROT_IDX))); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W      (ADDR_W),
  .SECTOR_BITS (SECTOR_BITS),
  .BLOCK_BITS  (BLOCK_BITS),
  .PROT_BLOCK  (PROT_BLOCK)
) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .engine_busy        (engine_busy),
  .wp_n               (wp_n),
  .start_prog         (start_prog),
  .start_sector_erase (start_sector_erase),
  .start_block_erase  (start_block_erase),
  .start_suspend      (start_suspend),
  .start_resume       (start_resume),
  .op_addr            (op_addr)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk;
  logic        rst_n;
  logic        ce_n, we_n;
  logic [20:0] addr;
  logic [7:0]  data;
  logic        busy, wp_n;
  logic        s_prog, s_sect, s_blk, s_susp, s_res;
  logic [20:0] op_addr;
  logic [7:0]  op_data;

  int n_run = 0;
  int n_fail = 0;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_data(data), .engine_busy(busy), .wp_n(wp_n),
    .start_prog(s_prog), .start_sector_erase(s_sect), .start_block_erase(s_blk),
    .start_suspend(s_susp), .start_resume(s_res), .op_addr(op_addr), .op_data(op_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // seq: 0 program prefix, 1 erase prefix, 2 no prefix, 3 broken prefix
  // kind: 0 none, 1 prog, 2 sector, 3 block, 4 suspend, 5 resume
  typedef struct packed {
    logic [1:0]  seq;
    logic [20:0] a;
    logic [7:0]  d;
    logic        wp;
    logic        bz;
    logic [2:0]  k;
    logic [20:0] ea;
    logic [7:0]  ed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'd0, 21'h1ABCD, 8'h5A, 1'b1, 1'b0, 3'd1, 21'h1ABCD, 8'h5A},
    '{2'd1, 21'h12345, 8'h50, 1'b1, 1'b0, 3'd2, 21'h12000, 8'h50},
    '{2'd1, 21'h1F0FF, 8'h30, 1'b1, 1'b0, 3'd3, 21'h10000, 8'h30},
    '{2'd1, 21'h00456, 8'h50, 1'b0, 1'b0, 3'd0, 21'h10000, 8'h30},
    '{2'd1, 21'h1A123, 8'h50, 1'b0, 1'b0, 3'd2, 21'h1A000, 8'h50},
    '{2'd1, 21'h0F123, 8'h30, 1'b1, 1'b0, 3'd3, 21'h00000, 8'h30},
    '{2'd1, 21'h0F123, 8'h30, 1'b0, 1'b0, 3'd0, 21'h00000, 8'h30},
    '{2'd0, 21'h00010, 8'h11, 1'b1, 1'b1, 3'd0, 21'h00000, 8'h30},
    '{2'd2, 21'h04321, 8'hB0, 1'b1, 1'b1, 3'd4, 21'h00000, 8'h30},
    '{2'd2, 21'h1FFFF, 8'h30, 1'b1, 1'b0, 3'd5, 21'h00000, 8'h30},
    '{2'd3, 21'h00077, 8'h22, 1'b1, 1'b0, 3'd0, 21'h00000, 8'h30},
    '{2'd0, 21'h00020, 8'h33, 1'b0, 1'b0, 3'd1, 21'h00020, 8'h33},
    '{2'd2, 21'h05555, 8'hB0, 1'b1, 1'b0, 3'd0, 21'h00020, 8'h33},
    '{2'd1, 21'h03000, 8'h10, 1'b1, 1'b0, 3'd0, 21'h00020, 8'h33}
  };

  function automatic logic [2:0] kind_seen();
    logic [2:0] kk;
    kk = 3'd0;
    if (s_prog) kk = 3'd1;
    if (s_sect) kk = 3'd2;
    if (s_blk)  kk = 3'd3;
    if (s_susp) kk = 3'd4;
    if (s_res)  kk = 3'd5;
    return kk;
  endfunction

  function automatic logic [4:0] all_starts();
    return {s_prog, s_sect, s_blk, s_susp, s_res};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic prog_prefix();
    bus_wr(21'h05555, 8'hAA);
    bus_wr(21'h02AAA, 8'h55);
    bus_wr(21'h05555, 8'hA0);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.k == 3'd1) return "R4";
    if (v.k == 3'd2) return "R5";
    if (v.k == 3'd3) return "R6";
    if (v.k >= 3'd4) return "R9";
    if (v.bz) return "R8";
    if (!v.wp) return "R10";
    return "R7";
  endfunction

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; data = '0; busy = 1'b0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "starts in reset", 32'(all_starts()), 32'd0);
    check("R1", "op_addr in reset", 32'(op_addr), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "starts after reset", 32'(all_starts()), 32'd0);
    check("R1", "op_data after reset", 32'(op_data), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VT[i];
      @(negedge clk); wp_n = v.wp; busy = v.bz;
      case (v.seq)
        2'd0: prog_prefix();
        2'd1: begin
          bus_wr(21'h05555, 8'hAA); bus_wr(21'h02AAA, 8'h55); bus_wr(21'h05555, 8'h80);
          bus_wr(21'h05555, 8'hAA); bus_wr(21'h02AAA, 8'h55);
        end
        2'd3: begin
          bus_wr(21'h05555, 8'hAA); bus_wr(21'h01234, 8'h55); bus_wr(21'h05555, 8'hA0);
        end
        default: ;
      endcase
      bus_wr(v.a, v.d);
      @(negedge clk);
      check("R11", "early pulse", 32'(all_starts()), 32'd0);
      @(negedge clk);
      check(tag_of(v), "kind", 32'(kind_seen()), 32'(v.k));
      check(tag_of(v), "op_addr", 32'(op_addr), 32'(v.ea));
      check(tag_of(v), "op_data", 32'(op_data), 32'(v.ed));
      @(negedge clk);
      check("R11", "pulse width", 32'(all_starts()), 32'd0);
      busy = 1'b0; wp_n = 1'b1;
    end

    // R2 and R3: CE falls first, address moves after WE falls, CE rises first
    prog_prefix();
    @(negedge clk); addr = 21'h01111; data = 8'h01; ce_n = 1'b0;
    @(negedge clk); addr = 21'h12222; we_n = 1'b0;
    @(negedge clk); addr = 21'h13333; data = 8'h02;
    @(negedge clk); data = 8'h03;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1; data = 8'hFF;
    @(negedge clk);
    check("R4", "prog after split strobes", 32'(s_prog), 32'd1);
    check("R2", "address at later fall", 32'(op_addr), 32'h12222);
    check("R3", "data before first rise", 32'(op_data), 32'h03);

    // R2: WE falls first, CE falls later with new address
    prog_prefix();
    @(negedge clk); addr = 21'h0AAAA; data = 8'h44; we_n = 1'b0;
    @(negedge clk); addr = 21'h0BBBB; ce_n = 1'b0;
    @(negedge clk); addr = 21'h0CCCC;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2", "address at CE fall", 32'(op_addr), 32'h0BBBB);
    check("R3", "data held", 32'(op_data), 32'h44);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule